// File: doc/BRIEF.md
# Bidirectional Multi-Lane Ring Stop

This block is one stop on an on-chip ring that runs both clockwise and counter-clockwise. Each direction is made of independent sub-rings for three message classes. Wide data blocks travel on a single lane. Commands with addresses and short acknowledgement messages each get a pair of lanes, so their bandwidth keeps pace with the one data lane. The stop passes transit traffic along one hop per clock. It removes messages whose destination ID equals its own and hands them to a local eject port. It takes messages from a local agent and places each one on a lane that fits its class and destination.

Each class has its own link bundle in each direction, its own inject port and its own eject port, and each port uses a valid/ready handshake. Messages already on the ring have priority: a local message is only placed into a slot that is empty at this stop. The ring length, this stop's ID, the three payload widths and the number of lanes in each request and acknowledgement pair are parameters. A flit is `{dst, payload}`, with the destination ID in the top `$clog2(RING_NODES)` bits. Link lanes are packed by index k = dir*LANES + lane, where dir is 0 for clockwise and 1 for counter-clockwise. LANES is 1 for data and REQ_LANES for the address and acknowledgement classes.

Top module: `ringstop_node`

## Requirements
- R1: An incoming valid flit whose destination differs from NODE_ID appears on the output link of the same lane index k on the next clock, bit for bit unchanged.
- R2: An incoming valid flit whose destination equals NODE_ID raises the eject valid of its class in the same cycle, with its payload (the flit without the destination bits). If it is taken (eject ready high) it leaves the ring and its output lane is empty on the next clock, unless a local inject fills that lane.
- R3: When the eject ready of a class is low, every matching flit of that class goes on to the output link of its own lane on the next clock, unchanged.
- R4: When several lanes of one class carry matching flits in the same cycle, the lowest lane index k is presented and ejected. All others continue on their own lanes.
- R5: An injected message goes clockwise when (dst - NODE_ID) mod RING_NODES <= (NODE_ID - dst) mod RING_NODES, and counter-clockwise otherwise. So ties go clockwise.
- R6: Within the chosen direction, an address or acknowledgement message uses lane (dst mod REQ_LANES), giving index k = dir*REQ_LANES + dst mod REQ_LANES. A data message uses index k = dir.
- R7: Inject ready of a class is high exactly when the incoming lane at the target index is empty or its flit is being ejected in this cycle. An accepted flit appears on the output link at the target index on the next clock.
- R8: No flit is lost or duplicated. Per class, the number of valid output lanes equals the previous cycle's valid inputs, minus the ejections and plus the accepted injections.
- R9: While reset is asserted, and at the first clock after it is released, every output lane is empty.
- R10: The three classes are independent. A full data ring neither blocks nor changes address or acknowledgement injection, and the reverse holds too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dat_lnk_vld_i | input | 2 | Data lanes arriving, valid per index k |
| dat_lnk_flit_i | input | 2*(ID_W+DATA_W) | Data flits arriving, lane k at k*(ID_W+DATA_W) |
| dat_lnk_vld_o | output | 2 | Data lanes leaving, valid per index k |
| dat_lnk_flit_o | output | 2*(ID_W+DATA_W) | Data flits leaving |
| dat_inj_vld_i | input | 1 | Local data message offered |
| dat_inj_rdy_o | output | 1 | Local data message accepted |
| dat_inj_flit_i | input | ID_W+DATA_W | Local data flit {dst, payload} |
| dat_ej_vld_o | output | 1 | Data message for this stop present |
| dat_ej_rdy_i | input | 1 | Local agent takes the data message |
| dat_ej_pay_o | output | DATA_W | Ejected data payload |
| adr_lnk_vld_i | input | 2*REQ_LANES | Address lanes arriving |
| adr_lnk_flit_i | input | 2*REQ_LANES*(ID_W+ADDR_W) | Address flits arriving |
| adr_lnk_vld_o | output | 2*REQ_LANES | Address lanes leaving |
| adr_lnk_flit_o | output | 2*REQ_LANES*(ID_W+ADDR_W) | Address flits leaving |
| adr_inj_vld_i | input | 1 | Local address message offered |
| adr_inj_rdy_o | output | 1 | Local address message accepted |
| adr_inj_flit_i | input | ID_W+ADDR_W | Local address flit |
| adr_ej_vld_o | output | 1 | Address message for this stop present |
| adr_ej_rdy_i | input | 1 | Local agent takes the address message |
| adr_ej_pay_o | output | ADDR_W | Ejected address payload |
| ack_lnk_vld_i | input | 2*REQ_LANES | Acknowledgement lanes arriving |
| ack_lnk_flit_i | input | 2*REQ_LANES*(ID_W+ACK_W) | Acknowledgement flits arriving |
| ack_lnk_vld_o | output | 2*REQ_LANES | Acknowledgement lanes leaving |
| ack_lnk_flit_o | output | 2*REQ_LANES*(ID_W+ACK_W) | Acknowledgement flits leaving |
| ack_inj_vld_i | input | 1 | Local acknowledgement offered |
| ack_inj_rdy_o | output | 1 | Local acknowledgement accepted |
| ack_inj_flit_i | input | ID_W+ACK_W | Local acknowledgement flit |
| ack_ej_vld_o | output | 1 | Acknowledgement for this stop present |
| ack_ej_rdy_i | input | 1 | Local agent takes the acknowledgement |
| ack_ej_pay_o | output | ACK_W | Ejected acknowledgement payload |

## Verification
The bench aims at the direction tie at half the ring length. A stop that broke the tie the other way would put the flit on a counter-clockwise lane. It also tests two matches in one cycle, where a wrong priority would eject the higher lane and drop or duplicate the other. An eject stall is covered too: a stop that dropped the flit there would leave an empty output lane instead of the circulating message. Injection is tried into a slot freed by ejection in the same cycle and into a slot held by transit traffic. A stop that got these wrong would either refuse a legal slot or overwrite a message in transit. Random mixed traffic across all three classes, against a bench model, catches lane-selection errors such as a wrong modulo or a swapped direction half, and catches any leak of traffic from one class into another.

// File: rtl/ringstop_pkg.sv
package ringstop_pkg;

  typedef enum logic {
    DIR_CW  = 1'b0,
    DIR_CCW = 1'b1
  } ring_dir_e;

  function automatic int unsigned cw_hops(int unsigned src, int unsigned dst, int unsigned n);
    return (dst + n - src) % n;
  endfunction

  function automatic int unsigned ccw_hops(int unsigned src, int unsigned dst, int unsigned n);
    return (src + n - dst) % n;
  endfunction

endpackage

// File: rtl/ringstop_route.sv
module ringstop_route
  import ringstop_pkg::*;
#(
  parameter int NODES   = 8,
  parameter int NODE_ID = 0,
  parameter int LANES   = 2,
  parameter int ID_W    = 3,
  parameter int IDX_W   = 2
) (
  input  logic [ID_W-1:0]  dst_i,
  output logic [IDX_W-1:0] idx_o
);

  ring_dir_e   dir;
  int unsigned cw_d;
  int unsigned ccw_d;
  int unsigned lane;
  int unsigned base;

  always_comb begin
    cw_d  = cw_hops(NODE_ID, 32'(dst_i), NODES);
    ccw_d = ccw_hops(NODE_ID, 32'(dst_i), NODES);
    dir   = (cw_d <= ccw_d) ? DIR_CW : DIR_CCW;
    lane  = 32'(dst_i) % LANES;
    base  = (dir == DIR_CCW) ? LANES : 0;
    idx_o = IDX_W'(base + lane);
  end

endmodule

// File: rtl/ringstop_slot.sv
module ringstop_slot #(
  parameter int FW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_vld_i,
  input  logic [FW-1:0] in_flit_i,
  input  logic          take_i,
  input  logic          inj_i,
  input  logic [FW-1:0] inj_flit_i,
  output logic          out_vld_o,
  output logic [FW-1:0] out_flit_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o  <= 1'b0;
      out_flit_o <= '0;
    end else if (inj_i) begin
      out_vld_o  <= 1'b1;
      out_flit_o <= inj_flit_i;
    end else begin
      out_vld_o  <= in_vld_i && !take_i;
      out_flit_o <= in_flit_i;
    end
  end

endmodule

// File: rtl/ringstop_class.sv
module ringstop_class #(
  parameter int NODES   = 8,
  parameter int NODE_ID = 0,
  parameter int LANES   = 2,
  parameter int PW      = 16,
  parameter int ID_W    = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [2*LANES-1:0]               lnk_vld_i,
  input  logic [2*LANES*(ID_W+PW)-1:0]     lnk_flit_i,
  output logic [2*LANES-1:0]               lnk_vld_o,
  output logic [2*LANES*(ID_W+PW)-1:0]     lnk_flit_o,
  input  logic                             inj_vld_i,
  output logic                             inj_rdy_o,
  input  logic [ID_W+PW-1:0]               inj_flit_i,
  output logic                             ej_vld_o,
  input  logic                             ej_rdy_i,
  output logic [PW-1:0]                    ej_pay_o
);

  localparam int FW    = ID_W + PW;
  localparam int K     = 2 * LANES;
  localparam int IDX_W = (K > 1) ? $clog2(K) : 1;

  logic [K-1:0]     hit;
  logic [K-1:0]     first;
  logic [K-1:0]     take;
  logic [K-1:0]     inj_sel;
  logic [IDX_W-1:0] inj_idx;
  logic             inj_fire;
  logic             found;

  for (genvar k = 0; k < K; k++) begin : g_hit
    assign hit[k] = lnk_vld_i[k] && (lnk_flit_i[k*FW+PW +: ID_W] == ID_W'(NODE_ID));
  end

  // lowest lane index wins the eject port
  always_comb begin
    first    = '0;
    found    = 1'b0;
    ej_pay_o = '0;
    for (int k = 0; k < K; k++) begin
      if (hit[k] && !found) begin
        first[k] = 1'b1;
        found    = 1'b1;
        ej_pay_o = lnk_flit_i[k*FW +: PW];
      end
    end
  end

  assign ej_vld_o = |hit;
  assign take     = ej_rdy_i ? first : '0;

  ringstop_route #(
    .NODES  (NODES),
    .NODE_ID(NODE_ID),
    .LANES  (LANES),
    .ID_W   (ID_W),
    .IDX_W  (IDX_W)
  ) u_route (
    .dst_i(inj_flit_i[PW +: ID_W]),
    .idx_o(inj_idx)
  );

  // ring traffic has priority: only an empty or freed slot takes a local flit
  assign inj_rdy_o = !lnk_vld_i[inj_idx] || take[inj_idx];
  assign inj_fire  = inj_vld_i && inj_rdy_o;

  for (genvar k = 0; k < K; k++) begin : g_slot
    assign inj_sel[k] = inj_fire && (inj_idx == IDX_W'(k));

    ringstop_slot #(.FW(FW)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .in_vld_i  (lnk_vld_i[k]),
      .in_flit_i (lnk_flit_i[k*FW +: FW]),
      .take_i    (take[k]),
      .inj_i     (inj_sel[k]),
      .inj_flit_i(inj_flit_i),
      .out_vld_o (lnk_vld_o[k]),
      .out_flit_o(lnk_flit_o[k*FW +: FW])
    );
  end

endmodule

// File: rtl/ringstop_node.sv
module ringstop_node #(
  parameter int RING_NODES = 8,
  parameter int NODE_ID    = 3,
  parameter int DATA_W     = 512,
  parameter int ADDR_W     = 64,
  parameter int ACK_W      = 16,
  parameter int REQ_LANES  = 2,
  localparam int ID_W      = $clog2(RING_NODES),
  localparam int DFW       = ID_W + DATA_W,
  localparam int AFW       = ID_W + ADDR_W,
  localparam int KFW       = ID_W + ACK_W,
  localparam int RK        = 2 * REQ_LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        dat_lnk_vld_i,
  input  logic [2*DFW-1:0]  dat_lnk_flit_i,
  output logic [1:0]        dat_lnk_vld_o,
  output logic [2*DFW-1:0]  dat_lnk_flit_o,
  input  logic              dat_inj_vld_i,
  output logic              dat_inj_rdy_o,
  input  logic [DFW-1:0]    dat_inj_flit_i,
  output logic              dat_ej_vld_o,
  input  logic              dat_ej_rdy_i,
  output logic [DATA_W-1:0] dat_ej_pay_o,
  input  logic [RK-1:0]     adr_lnk_vld_i,
  input  logic [RK*AFW-1:0] adr_lnk_flit_i,
  output logic [RK-1:0]     adr_lnk_vld_o,
  output logic [RK*AFW-1:0] adr_lnk_flit_o,
  input  logic              adr_inj_vld_i,
  output logic              adr_inj_rdy_o,
  input  logic [AFW-1:0]    adr_inj_flit_i,
  output logic              adr_ej_vld_o,
  input  logic              adr_ej_rdy_i,
  output logic [ADDR_W-1:0] adr_ej_pay_o,
  input  logic [RK-1:0]     ack_lnk_vld_i,
  input  logic [RK*KFW-1:0] ack_lnk_flit_i,
  output logic [RK-1:0]     ack_lnk_vld_o,
  output logic [RK*KFW-1:0] ack_lnk_flit_o,
  input  logic              ack_inj_vld_i,
  output logic              ack_inj_rdy_o,
  input  logic [KFW-1:0]    ack_inj_flit_i,
  output logic              ack_ej_vld_o,
  input  logic              ack_ej_rdy_i,
  output logic [ACK_W-1:0]  ack_ej_pay_o
);

  ringstop_class #(
    .NODES(RING_NODES), .NODE_ID(NODE_ID), .LANES(1), .PW(DATA_W), .ID_W(ID_W)
  ) u_dat (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lnk_vld_i(dat_lnk_vld_i), .lnk_flit_i(dat_lnk_flit_i),
    .lnk_vld_o(dat_lnk_vld_o), .lnk_flit_o(dat_lnk_flit_o),
    .inj_vld_i(dat_inj_vld_i), .inj_rdy_o(dat_inj_rdy_o), .inj_flit_i(dat_inj_flit_i),
    .ej_vld_o(dat_ej_vld_o), .ej_rdy_i(dat_ej_rdy_i), .ej_pay_o(dat_ej_pay_o)
  );

  ringstop_class #(
    .NODES(RING_NODES), .NODE_ID(NODE_ID), .LANES(REQ_LANES), .PW(ADDR_W), .ID_W(ID_W)
  ) u_adr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lnk_vld_i(adr_lnk_vld_i), .lnk_flit_i(adr_lnk_flit_i),
    .lnk_vld_o(adr_lnk_vld_o), .lnk_flit_o(adr_lnk_flit_o),
    .inj_vld_i(adr_inj_vld_i), .inj_rdy_o(adr_inj_rdy_o), .inj_flit_i(adr_inj_flit_i),
    .ej_vld_o(adr_ej_vld_o), .ej_rdy_i(adr_ej_rdy_i), .ej_pay_o(adr_ej_pay_o)
  );

  ringstop_class #(
    .NODES(RING_NODES), .NODE_ID(NODE_ID), .LANES(REQ_LANES), .PW(ACK_W), .ID_W(ID_W)
  ) u_ack (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lnk_vld_i(ack_lnk_vld_i), .lnk_flit_i(ack_lnk_flit_i),
    .lnk_vld_o(ack_lnk_vld_o), .lnk_flit_o(ack_lnk_flit_o),
    .inj_vld_i(ack_inj_vld_i), .inj_rdy_o(ack_inj_rdy_o), .inj_flit_i(ack_inj_flit_i),
    .ej_vld_o(ack_ej_vld_o), .ej_rdy_i(ack_ej_rdy_i), .ej_pay_o(ack_ej_pay_o)
  );

endmodule

// File: rtl/ringstop_node_chk.sv
module ringstop_node_chk #(
  parameter int RING_NODES = 8,
  parameter int NODE_ID    = 3,
  parameter int DATA_W     = 512,
  parameter int ADDR_W     = 64,
  parameter int ACK_W      = 16,
  parameter int REQ_LANES  = 2,
  localparam int ID_W      = $clog2(RING_NODES),
  localparam int DFW       = ID_W + DATA_W,
  localparam int AFW       = ID_W + ADDR_W,
  localparam int KFW       = ID_W + ACK_W,
  localparam int RK        = 2 * REQ_LANES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        dat_lnk_vld_i,
  input logic [1:0]        dat_lnk_vld_o,
  input logic              dat_inj_vld_i,
  input logic              dat_inj_rdy_o,
  input logic              dat_ej_vld_o,
  input logic              dat_ej_rdy_i,
  input logic [RK-1:0]     adr_lnk_vld_i,
  input logic [RK*AFW-1:0] adr_lnk_flit_i,
  input logic [RK-1:0]     adr_lnk_vld_o,
  input logic [RK*AFW-1:0] adr_lnk_flit_o,
  input logic              adr_inj_vld_i,
  input logic              adr_inj_rdy_o,
  input logic              adr_ej_vld_o,
  input logic              adr_ej_rdy_i,
  input logic [RK-1:0]     ack_lnk_vld_i,
  input logic [RK-1:0]     ack_lnk_vld_o,
  input logic              ack_inj_vld_i,
  input logic              ack_inj_rdy_o,
  input logic              ack_ej_vld_o,
  input logic              ack_ej_rdy_i
);

  assert_reset_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (dat_lnk_vld_o == '0 && adr_lnk_vld_o == '0 && ack_lnk_vld_o == '0));

  assert_dat_conserve_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $countones(dat_lnk_vld_o) ==
      $past($countones(dat_lnk_vld_i)) - 32'($past(dat_ej_vld_o && dat_ej_rdy_i))
      + 32'($past(dat_inj_vld_i && dat_inj_rdy_o)));

  assert_adr_conserve_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $countones(adr_lnk_vld_o) ==
      $past($countones(adr_lnk_vld_i)) - 32'($past(adr_ej_vld_o && adr_ej_rdy_i))
      + 32'($past(adr_inj_vld_i && adr_inj_rdy_o)));

  assert_ack_conserve_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $countones(ack_lnk_vld_o) ==
      $past($countones(ack_lnk_vld_i)) - 32'($past(ack_ej_vld_o && ack_ej_rdy_i))
      + 32'($past(ack_inj_vld_i && ack_inj_rdy_o)));

  assert_inj_lands_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adr_inj_vld_i && adr_inj_rdy_o |=> adr_lnk_vld_o != '0);

  for (genvar k = 0; k < RK; k++) begin : g_lane
    assert_pass_through_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adr_lnk_vld_i[k] && adr_lnk_flit_i[k*AFW+ADDR_W +: ID_W] != ID_W'(NODE_ID)
      |=> adr_lnk_vld_o[k] && adr_lnk_flit_o[k*AFW +: AFW] == $past(adr_lnk_flit_i[k*AFW +: AFW]));

    assert_stall_circulates_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adr_lnk_vld_i[k] && adr_lnk_flit_i[k*AFW+ADDR_W +: ID_W] == ID_W'(NODE_ID) && !adr_ej_rdy_i
      |=> adr_lnk_vld_o[k] && adr_lnk_flit_o[k*AFW +: AFW] == $past(adr_lnk_flit_i[k*AFW +: AFW]));
  end

endmodule

bind ringstop_node ringstop_node_chk #(
  .RING_NODES(RING_NODES), .NODE_ID(NODE_ID), .DATA_W(DATA_W),
  .ADDR_W(ADDR_W), .ACK_W(ACK_W), .REQ_LANES(REQ_LANES)
) u_chk (.*);

// File: tb/ringstop_node_test.sv
module ringstop_node_test;

  localparam int N   = 8;
  localparam int ID  = 3;
  localparam int DW  = 512;
  localparam int AW  = 64;
  localparam int KW  = 16;
  localparam int L   = 2;
  localparam int IW  = 3;
  localparam int DFW = IW + DW;
  localparam int AFW = IW + AW;
  localparam int KFW = IW + KW;
  localparam int FM  = DFW;

  typedef logic [FM-1:0] flit_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;

  logic [1:0]       dat_lnk_vld_i, dat_lnk_vld_o;
  logic [2*DFW-1:0] dat_lnk_flit_i, dat_lnk_flit_o;
  logic             dat_inj_vld_i, dat_inj_rdy_o, dat_ej_vld_o, dat_ej_rdy_i;
  logic [DFW-1:0]   dat_inj_flit_i;
  logic [DW-1:0]    dat_ej_pay_o;
  logic [3:0]       adr_lnk_vld_i, adr_lnk_vld_o;
  logic [4*AFW-1:0] adr_lnk_flit_i, adr_lnk_flit_o;
  logic             adr_inj_vld_i, adr_inj_rdy_o, adr_ej_vld_o, adr_ej_rdy_i;
  logic [AFW-1:0]   adr_inj_flit_i;
  logic [AW-1:0]    adr_ej_pay_o;
  logic [3:0]       ack_lnk_vld_i, ack_lnk_vld_o;
  logic [4*KFW-1:0] ack_lnk_flit_i, ack_lnk_flit_o;
  logic             ack_inj_vld_i, ack_inj_rdy_o, ack_ej_vld_o, ack_ej_rdy_i;
  logic [KFW-1:0]   ack_inj_flit_i;
  logic [KW-1:0]    ack_ej_pay_o;

  ringstop_node #(
    .RING_NODES(N), .NODE_ID(ID), .DATA_W(DW), .ADDR_W(AW), .ACK_W(KW), .REQ_LANES(L)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .dat_lnk_vld_i(dat_lnk_vld_i), .dat_lnk_flit_i(dat_lnk_flit_i),
    .dat_lnk_vld_o(dat_lnk_vld_o), .dat_lnk_flit_o(dat_lnk_flit_o),
    .dat_inj_vld_i(dat_inj_vld_i), .dat_inj_rdy_o(dat_inj_rdy_o), .dat_inj_flit_i(dat_inj_flit_i),
    .dat_ej_vld_o(dat_ej_vld_o), .dat_ej_rdy_i(dat_ej_rdy_i), .dat_ej_pay_o(dat_ej_pay_o),
    .adr_lnk_vld_i(adr_lnk_vld_i), .adr_lnk_flit_i(adr_lnk_flit_i),
    .adr_lnk_vld_o(adr_lnk_vld_o), .adr_lnk_flit_o(adr_lnk_flit_o),
    .adr_inj_vld_i(adr_inj_vld_i), .adr_inj_rdy_o(adr_inj_rdy_o), .adr_inj_flit_i(adr_inj_flit_i),
    .adr_ej_vld_o(adr_ej_vld_o), .adr_ej_rdy_i(adr_ej_rdy_i), .adr_ej_pay_o(adr_ej_pay_o),
    .ack_lnk_vld_i(ack_lnk_vld_i), .ack_lnk_flit_i(ack_lnk_flit_i),
    .ack_lnk_vld_o(ack_lnk_vld_o), .ack_lnk_flit_o(ack_lnk_flit_o),
    .ack_inj_vld_i(ack_inj_vld_i), .ack_inj_rdy_o(ack_inj_rdy_o), .ack_inj_flit_i(ack_inj_flit_i),
    .ack_ej_vld_o(ack_ej_vld_o), .ack_ej_rdy_i(ack_ej_rdy_i), .ack_ej_pay_o(ack_ej_pay_o)
  );

  always #5 clk_i = ~clk_i;

  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;
  logic [3:0] exp_v [3];
  flit_t      exp_f [3][4];

  task automatic chk(string tag, flit_t act, flit_t exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int lanes_of(int c); return (c == 0) ? 1 : L; endfunction
  function automatic int pw_of(int c);
    return (c == 0) ? DW : (c == 1) ? AW : KW;
  endfunction
  function automatic flit_t pmask(int pw); return (flit_t'(1) << pw) - flit_t'(1); endfunction
  function automatic int dst_of(flit_t f, int pw); return int'(f[pw +: IW]); endfunction

  function automatic flit_t mk(int c, int dst, flit_t pay);
    return (flit_t'(dst) << pw_of(c)) | (pay & pmask(pw_of(c)));
  endfunction

  function automatic flit_t rnd_pay();
    flit_t r = '0;
    repeat (17) r = {r[FM-33:0], 32'($urandom())};
    return r;
  endfunction

  function automatic logic [3:0] vin(int c);
    case (c) 0: return {2'b00, dat_lnk_vld_i}; 1: return adr_lnk_vld_i; default: return ack_lnk_vld_i; endcase
  endfunction
  function automatic logic [3:0] vout(int c);
    case (c) 0: return {2'b00, dat_lnk_vld_o}; 1: return adr_lnk_vld_o; default: return ack_lnk_vld_o; endcase
  endfunction
  function automatic flit_t fin(int c, int k);
    case (c)
      0: return flit_t'(dat_lnk_flit_i[k*DFW +: DFW]);
      1: return flit_t'(adr_lnk_flit_i[k*AFW +: AFW]);
      default: return flit_t'(ack_lnk_flit_i[k*KFW +: KFW]);
    endcase
  endfunction
  function automatic flit_t fout(int c, int k);
    case (c)
      0: return flit_t'(dat_lnk_flit_o[k*DFW +: DFW]);
      1: return flit_t'(adr_lnk_flit_o[k*AFW +: AFW]);
      default: return flit_t'(ack_lnk_flit_o[k*KFW +: KFW]);
    endcase
  endfunction
  function automatic logic ejr(int c);
    case (c) 0: return dat_ej_rdy_i; 1: return adr_ej_rdy_i; default: return ack_ej_rdy_i; endcase
  endfunction
  function automatic logic ejv(int c);
    case (c) 0: return dat_ej_vld_o; 1: return adr_ej_vld_o; default: return ack_ej_vld_o; endcase
  endfunction
  function automatic flit_t ejp(int c);
    case (c) 0: return flit_t'(dat_ej_pay_o); 1: return flit_t'(adr_ej_pay_o); default: return flit_t'(ack_ej_pay_o); endcase
  endfunction
  function automatic logic injv(int c);
    case (c) 0: return dat_inj_vld_i; 1: return adr_inj_vld_i; default: return ack_inj_vld_i; endcase
  endfunction
  function automatic logic injr(int c);
    case (c) 0: return dat_inj_rdy_o; 1: return adr_inj_rdy_o; default: return ack_inj_rdy_o; endcase
  endfunction
  function automatic flit_t injf(int c);
    case (c) 0: return flit_t'(dat_inj_flit_i); 1: return flit_t'(adr_inj_flit_i); default: return flit_t'(ack_inj_flit_i); endcase
  endfunction

  task automatic set_lane(int c, int k, logic v, flit_t f);
    case (c)
      0: begin dat_lnk_vld_i[k] = v; dat_lnk_flit_i[k*DFW +: DFW] = f[DFW-1:0]; end
      1: begin adr_lnk_vld_i[k] = v; adr_lnk_flit_i[k*AFW +: AFW] = f[AFW-1:0]; end
      default: begin ack_lnk_vld_i[k] = v; ack_lnk_flit_i[k*KFW +: KFW] = f[KFW-1:0]; end
    endcase
  endtask
  task automatic set_inj(int c, logic v, flit_t f);
    case (c)
      0: begin dat_inj_vld_i = v; dat_inj_flit_i = f[DFW-1:0]; end
      1: begin adr_inj_vld_i = v; adr_inj_flit_i = f[AFW-1:0]; end
      default: begin ack_inj_vld_i = v; ack_inj_flit_i = f[KFW-1:0]; end
    endcase
  endtask
  task automatic set_ejr(int c, logic r);
    case (c) 0: dat_ej_rdy_i = r; 1: adr_ej_rdy_i = r; default: ack_ej_rdy_i = r; endcase
  endtask

  task automatic clear_stim();
    for (int c = 0; c < 3; c++) begin
      for (int k = 0; k < 2*lanes_of(c); k++) set_lane(c, k, 1'b0, '0);
      set_inj(c, 1'b0, '0);
      set_ejr(c, 1'b1);
    end
  endtask

  // model of one class, from the requirements
  task automatic comb_check(int c);
    int ln = lanes_of(c);
    int pw = pw_of(c);
    int first = -1;
    int di, cw, ccw, t;
    logic e_rdy;
    for (int k = 0; k < 2*ln; k++)
      if (vin(c)[k] && dst_of(fin(c, k), pw) == ID && first < 0) first = k;
    chk("R2 eject valid", flit_t'(ejv(c)), flit_t'(first >= 0));
    if (first >= 0) chk("R4 eject payload", ejp(c), fin(c, first) & pmask(pw));
    di  = dst_of(injf(c), pw);
    cw  = (di + N - ID) % N;
    ccw = (ID + N - di) % N;
    t   = ((cw <= ccw) ? 0 : ln) + (di % ln);
    e_rdy = !vin(c)[t] || (ejr(c) && t == first);
    chk("R7 inject ready", flit_t'(injr(c)), flit_t'(e_rdy));
    exp_v[c] = '0;
    for (int k = 0; k < 2*ln; k++) begin
      exp_v[c][k] = vin(c)[k] && !(ejr(c) && k == first);
      exp_f[c][k] = fin(c, k);
    end
    if (injv(c) && e_rdy) begin
      exp_v[c][t] = 1'b1;
      exp_f[c][t] = injf(c);
    end
  endtask

  task automatic out_check(int c);
    for (int k = 0; k < 2*lanes_of(c); k++) begin
      chk("R1 R5 R6 R8 lane valid", flit_t'(vout(c)[k]), flit_t'(exp_v[c][k]));
      if (exp_v[c][k]) chk("R1 R10 lane flit", fout(c, k), exp_f[c][k]);
    end
  endtask

  task automatic cycle();
    #4;
    for (int c = 0; c < 3; c++) comb_check(c);
    @(posedge clk_i);
    #1;
    for (int c = 0; c < 3; c++) out_check(c);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    flit_t f1, f3;
    void'($urandom(32'd4711));
    clear_stim();
    repeat (3) @(negedge clk_i);
    chk("R9 reset data empty", flit_t'(vout(0)), '0);
    chk("R9 reset addr empty", flit_t'(vout(1)), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 released addr empty", flit_t'(vout(1)), '0);
    chk("R9 released ack empty", flit_t'(vout(2)), '0);

    // tie at half ring: dst 7 from 3 is 4 hops either way
    clear_stim(); set_inj(1, 1'b1, mk(1, 7, rnd_pay())); cycle();
    chk("R5 tie goes clockwise, lane 1", flit_t'(vout(1)), flit_t'(4'b0010));
    clear_stim(); set_inj(1, 1'b1, mk(1, 0, rnd_pay())); cycle();
    chk("R5 shorter counter-clockwise", flit_t'(vout(1)), flit_t'(4'b0100));
    clear_stim(); set_inj(0, 1'b1, mk(0, 6, rnd_pay())); set_inj(2, 1'b1, mk(2, 5, rnd_pay())); cycle();
    chk("R6 data single lane", flit_t'(vout(0)), flit_t'(4'b0001));
    chk("R6 ack lane dst mod 2", flit_t'(vout(2)), flit_t'(4'b0010));

    clear_stim(); f1 = mk(1, ID, rnd_pay()); set_lane(1, 2, 1'b1, f1); set_ejr(1, 1'b0); cycle();
    chk("R3 stalled eject keeps lane", flit_t'(vout(1)), flit_t'(4'b0100));
    chk("R3 stalled flit unchanged", fout(1, 2), f1);

    clear_stim(); f1 = mk(1, ID, rnd_pay()); f3 = mk(1, ID, rnd_pay());
    set_lane(1, 1, 1'b1, f1); set_lane(1, 3, 1'b1, f3); cycle();
    chk("R4 lower lane ejected", flit_t'(vout(1)), flit_t'(4'b1000));
    chk("R4 other match circulates", fout(1, 3), f3);

    clear_stim(); f1 = mk(1, 5, rnd_pay()); set_lane(1, 1, 1'b1, f1);
    set_inj(1, 1'b1, mk(1, 7, rnd_pay())); cycle();
    chk("R7 occupied slot keeps transit flit", fout(1, 1), f1);
    clear_stim(); set_lane(1, 1, 1'b1, mk(1, ID, rnd_pay()));
    f3 = mk(1, 7, rnd_pay()); set_inj(1, 1'b1, f3); cycle();
    chk("R7 freed slot takes injected flit", fout(1, 1), f3);

    clear_stim(); set_lane(0, 0, 1'b1, mk(0, 5, rnd_pay())); set_lane(0, 1, 1'b1, mk(0, 1, rnd_pay()));
    set_inj(0, 1'b1, mk(0, 6, rnd_pay())); set_inj(1, 1'b1, mk(1, 7, rnd_pay())); cycle();
    chk("R10 addr injects beside full data ring", flit_t'(vout(1)), flit_t'(4'b0010));
    chk("R10 data ring untouched", flit_t'(vout(0)), flit_t'(4'b0011));

    for (int i = 0; i < 3000; i++) begin
      for (int c = 0; c < 3; c++) begin
        for (int k = 0; k < 2*lanes_of(c); k++) begin
          int d = ($urandom_range(99) < 35) ? ID : int'($urandom_range(N-1));
          set_lane(c, k, ($urandom_range(99) < 60), mk(c, d, rnd_pay()));
        end
        set_inj(c, ($urandom_range(99) < 70), mk(c, int'($urandom_range(N-1)), rnd_pay()));
        set_ejr(c, ($urandom_range(99) < 70));
      end
      cycle();
    end
    finish_run();
  end

endmodule